// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status Flags

This block receives asynchronous serial characters from a single line that is sampled with an external tick strobe. The clock divider is outside the block and supplies one tick per oversampling period. Software selects 16 or 8 ticks per bit. A character is 8 or 9 payload bits, with or without a parity bit, and ends with a stop bit. Each bit is decided by a vote over three ticks around the middle of the bit. A start edge that does not hold until mid-bit is dropped.

The host reaches the block through a small word-addressed bus. Address 0 is the status word, address 1 is the received character and address 2 is the control word. The host normally reads the status word and then the character. This pair of reads retires the character together with the error flags that came with it. The block also flags an idle line after a character and a break, which is an all-zero frame. One interrupt line combines the flags whose enables are set.

Top module: `uart_rx_core`

## Requirements
- R1: After reset the status, data and control words all read 0 and `irq` is low.
- R2: The control word is address 2, and it reads back as written. The receiver runs only when control bit 13 (block on) and bit 2 (receive on) are both 1. A completed character sets status bit 5 (character ready) and appears in data word bits 8:0 (address 1), and the upper data bits read 0.
- R3: Control bit 12 = 1 selects 9 payload bits. Without parity all 9 bits reach the data word.
- R4: Control bit 10 enables parity and bit 9 selects odd (1) or even (0). The last payload bit is then parity, so 9 payload bits carry 8 data bits and 8 payload bits carry 7 data bits. The parity position reads 0 in the data word, and a mismatch sets status bit 0.
- R5: A stop bit that the vote decides as low sets status bit 1. After that, no new start is accepted until the line has gone high.
- R6: If the three votes of any bit in a frame disagree, status bit 2 is set and the character holds the majority values.
- R7: A character that completes while bit 5 is still set sets status bit 3. That character is discarded and the previous one is kept.
- R8: Reading the data word clears bit 5. If the status word was the previous read, the same data read also clears bits 0, 1, 2, 3 and 4.
- R9: Status bit 4 (idle) sets once the line has stayed high for one whole frame time after a character. A frame time is (payload bits + 2) bit times.
- R10: A frame with all payload bits and the stop bit low sets status bit 8 as well as bit 1. Bit 8 survives the status-then-data read, and writing status with bit 8 = 0 clears it.
- R11: A low pulse on the line that ends before mid-bit produces no character.
- R12: While control bit 13 or bit 2 is 0, traffic on the line produces no character.
- R13: `irq` is the OR of three terms: (bit 5 enable = control bit 5) AND (ready OR overrun), (control bit 4) AND idle, and (control bit 8) AND parity error.
- R14: Control bit 15 = 1 switches to 8 ticks per bit. The three votes then sit on ticks 3, 4 and 5 of each bit instead of 7, 8 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversampling strobe, one clock wide |
| rx_in | input | 1 | Serial receive line, idle high |
| bus_addr | input | 2 | Word address: 0 status, 1 data, 2 control |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read side effects take place at the clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
The line passes through two synchronizer flops, and start detection can be up to one tick late. A character therefore reaches the registers roughly half a bit after the stop bit begins, plus a tick and three clocks. The bench reads the status word eight clocks after it finishes driving the stop bit, which leaves about half a bit of margin. The idle flag is due one frame time after that stop-bit vote. The bench brackets it with a read 2 bit times after the frame, where the flag must be clear, and a read 11 bit times after, where it must be set. Bus reads are sampled one time step after the address is driven. Their side effects are checked by a later read, after the next clock edge.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;

  localparam int ST_PE   = 0;
  localparam int ST_FE   = 1;
  localparam int ST_NF   = 2;
  localparam int ST_ORE  = 3;
  localparam int ST_IDLE = 4;
  localparam int ST_RDY  = 5;
  localparam int ST_BRK  = 8;

  localparam int CT_RE     = 2;
  localparam int CT_IDLEIE = 4;
  localparam int CT_RDYIE  = 5;
  localparam int CT_PEIE   = 8;
  localparam int CT_ODD    = 9;
  localparam int CT_PEN    = 10;
  localparam int CT_W9     = 12;
  localparam int CT_ON     = 13;
  localparam int CT_OS8    = 15;

  typedef enum logic [1:0] {FR_IDLE, FR_START, FR_DATA, FR_STOP} frame_st_t;

  typedef struct packed {
    logic [8:0] payload;
    logic       fe;
    logic       nf;
    logic       brk;
  } rx_char_t;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic split3(input logic a, input logic b, input logic c);
    return (a != b) || (b != c);
  endfunction

  // Data bits of a payload; the parity position is zeroed.
  function automatic logic [8:0] char_value(input logic [8:0] p, input logic w9,
                                            input logic pen);
    if (!pen) return w9 ? p : {1'b0, p[7:0]};
    return w9 ? {1'b0, p[7:0]} : {2'b00, p[6:0]};
  endfunction

  function automatic logic parity_bad(input logic [8:0] p, input logic w9,
                                      input logic pen, input logic odd);
    logic x;
    x = w9 ? ^p : ^p[7:0];
    return pen && (x != odd);
  endfunction

  function automatic int frame_ticks(input logic w9, input logic os8,
                                     input int hi, input int lo);
    return (w9 ? 11 : 10) * (os8 ? lo : hi);
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= '1;
        else        pipe <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], d};
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OS_HI = 16,
  parameter int OS_LO = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     tick,
  input  logic     rx_s,
  input  logic     os8,
  input  logic     w9,
  output logic     done,
  output rx_char_t chr,
  output logic     busy
);
  localparam int CW = $clog2(OS_HI + 1);

  frame_st_t      st;
  logic [CW-1:0]  cnt, os_n, mid;
  logic [1:0]     smp;
  logic [3:0]     idx, last_idx;
  logic [8:0]     sh;
  logic           nf_acc, wait_hi;
  logic           bit_v, bit_n, at_lo, at_mid, at_hi, at_end;

  assign os_n     = os8 ? CW'(OS_LO) : CW'(OS_HI);
  assign mid      = os_n >> 1;
  assign at_lo    = (cnt == mid - CW'(1));
  assign at_mid   = (cnt == mid);
  assign at_hi    = (cnt == mid + CW'(1));
  assign at_end   = (cnt == os_n - CW'(1));
  assign bit_v    = vote3(smp[0], smp[1], rx_s);
  assign bit_n    = split3(smp[0], smp[1], rx_s);
  assign last_idx = w9 ? 4'd8 : 4'd7;
  assign busy     = (st != FR_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= FR_IDLE; cnt <= '0; smp <= '0; idx <= '0; sh <= '0;
      nf_acc <= 1'b0; wait_hi <= 1'b0; done <= 1'b0; chr <= '0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        st <= FR_IDLE;
        wait_hi <= 1'b0;
      end else if (tick) begin
        if (st == FR_IDLE) begin
          if (wait_hi) begin
            if (rx_s) wait_hi <= 1'b0;
          end else if (!rx_s) begin
            st <= FR_START; cnt <= CW'(1); sh <= '0; nf_acc <= 1'b0;
          end
        end else begin
          cnt <= at_end ? '0 : cnt + CW'(1);
          if (at_lo)  smp[0] <= rx_s;
          if (at_mid) smp[1] <= rx_s;
          case (st)
            FR_START:
              if (at_hi) begin
                if (bit_v) st <= FR_IDLE;
                else       nf_acc <= bit_n;
              end else if (at_end) begin
                st <= FR_DATA; idx <= '0;
              end
            FR_DATA:
              if (at_hi) begin
                sh[idx] <= bit_v;
                nf_acc  <= nf_acc | bit_n;
              end else if (at_end) begin
                idx <= idx + 4'd1;
                if (idx == last_idx) st <= FR_STOP;
              end
            FR_STOP:
              if (at_hi) begin
                done        <= 1'b1;
                chr.payload <= sh;
                chr.fe      <= !bit_v;
                chr.nf      <= nf_acc | bit_n;
                chr.brk     <= !bit_v && (sh == '0);
                wait_hi     <= !bit_v;
                st          <= FR_IDLE;
              end
            default: st <= FR_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle
  import uart_rx_pkg::*;
#(
  parameter int OS_HI = 16,
  parameter int OS_LO = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic rx_s,
  input  logic char_done,
  input  logic os8,
  input  logic w9,
  output logic idle_set
);
  localparam int IW = $clog2(11 * OS_HI + 1);

  logic [IW-1:0] cnt, limit;
  logic          armed;

  assign limit = IW'(frame_ticks(w9, os8, OS_HI, OS_LO));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; armed <= 1'b0; idle_set <= 1'b0;
    end else begin
      idle_set <= 1'b0;
      if (!en) begin
        cnt <= '0; armed <= 1'b0;
      end else if (char_done) begin
        cnt <= '0; armed <= 1'b1;
      end else if (!rx_s) begin
        cnt <= '0;
      end else if (tick && armed) begin
        if (cnt == limit - IW'(1)) begin
          idle_set <= 1'b1; armed <= 1'b0; cnt <= '0;
        end else begin
          cnt <= cnt + IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  addr,
  input  logic        wr,
  input  logic        rd,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        char_done,
  input  rx_char_t    chr,
  input  logic        idle_set,
  output logic        rx_en,
  output logic        os8,
  output logic        w9,
  output logic        ie_rdy,
  output logic        f_rdy,
  output logic        f_ore,
  output logic        f_idle,
  output logic        sr_seen,
  output logic        data_rd,
  output logic        irq
);
  logic [15:0] ctrl, stat;
  logic [8:0]  dreg;
  logic        f_pe, f_fe, f_nf, f_brk;
  logic        stat_rd, stat_wr, ctrl_wr, err_clr, full;

  assign stat_rd = rd && (addr == A_STAT);
  assign data_rd = rd && (addr == A_DATA);
  assign stat_wr = wr && (addr == A_STAT);
  assign ctrl_wr = wr && (addr == A_CTRL);
  assign err_clr = data_rd && sr_seen;
  assign full    = f_rdy && !data_rd;

  assign rx_en  = ctrl[CT_ON] & ctrl[CT_RE];
  assign os8    = ctrl[CT_OS8];
  assign w9     = ctrl[CT_W9];
  assign ie_rdy = ctrl[CT_RDYIE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; dreg <= '0; sr_seen <= 1'b0;
      f_rdy <= 1'b0; f_pe <= 1'b0; f_fe <= 1'b0; f_nf <= 1'b0;
      f_ore <= 1'b0; f_idle <= 1'b0; f_brk <= 1'b0;
    end else begin
      if (stat_rd)      sr_seen <= 1'b1;
      else if (data_rd) sr_seen <= 1'b0;
      if (ctrl_wr) ctrl <= wdata;

      if (char_done && !full) begin
        f_rdy <= 1'b1;
        dreg  <= char_value(chr.payload, ctrl[CT_W9], ctrl[CT_PEN]);
        f_pe  <= parity_bad(chr.payload, ctrl[CT_W9], ctrl[CT_PEN], ctrl[CT_ODD]);
        f_fe  <= chr.fe;
        f_nf  <= chr.nf;
      end else begin
        if (data_rd) f_rdy <= 1'b0;
        if (err_clr) begin f_pe <= 1'b0; f_fe <= 1'b0; f_nf <= 1'b0; end
      end

      if (char_done && full) f_ore <= 1'b1;
      else if (err_clr)      f_ore <= 1'b0;

      if (idle_set)     f_idle <= 1'b1;
      else if (err_clr) f_idle <= 1'b0;

      if (char_done && !full && chr.brk)  f_brk <= 1'b1;
      else if (stat_wr && !wdata[ST_BRK]) f_brk <= 1'b0;
    end
  end

  always_comb begin
    stat          = '0;
    stat[ST_PE]   = f_pe;
    stat[ST_FE]   = f_fe;
    stat[ST_NF]   = f_nf;
    stat[ST_ORE]  = f_ore;
    stat[ST_IDLE] = f_idle;
    stat[ST_RDY]  = f_rdy;
    stat[ST_BRK]  = f_brk;
    case (addr)
      A_STAT:  rdata = stat;
      A_DATA:  rdata = {7'b0, dreg};
      A_CTRL:  rdata = ctrl;
      default: rdata = '0;
    endcase
  end

  assign irq = (ctrl[CT_RDYIE] & (f_rdy | f_ore)) |
               (ctrl[CT_IDLEIE] & f_idle) |
               (ctrl[CT_PEIE] & f_pe);
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OS_HI       = 16,
  parameter int OS_LO       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        rx_in,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq
);
  logic     rx_s, rx_en, os8, w9, ie_rdy;
  logic     char_done, frame_busy, idle_set;
  logic     f_rdy, f_ore, f_idle, sr_seen, data_rd;
  rx_char_t chr;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_in), .q(rx_s)
  );

  uart_rx_frame #(.OS_HI(OS_HI), .OS_LO(OS_LO)) u_frame (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick), .rx_s(rx_s),
    .os8(os8), .w9(w9), .done(char_done), .chr(chr), .busy(frame_busy)
  );

  uart_rx_idle #(.OS_HI(OS_HI), .OS_LO(OS_LO)) u_idle (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick), .rx_s(rx_s),
    .char_done(char_done), .os8(os8), .w9(w9), .idle_set(idle_set)
  );

  uart_rx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .rdata(bus_rdata), .char_done(char_done), .chr(chr),
    .idle_set(idle_set), .rx_en(rx_en), .os8(os8), .w9(w9), .ie_rdy(ie_rdy),
    .f_rdy(f_rdy), .f_ore(f_ore), .f_idle(f_idle), .sr_seen(sr_seen),
    .data_rd(data_rd), .irq(irq)
  );
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_s,
  input logic rx_en,
  input logic frame_busy,
  input logic char_done,
  input logic f_rdy,
  input logic f_ore,
  input logic f_idle,
  input logic sr_seen,
  input logic data_rd,
  input logic ie_rdy,
  input logic irq
);
  // R12
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !frame_busy);

  // R2
  rdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && !f_rdy) |=> f_rdy);

  // R7
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && f_rdy && !data_rd) |=> (f_ore && f_rdy));

  // R8
  clr_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && sr_seen && !char_done) |=> (!f_ore && !f_rdy && !f_idle));

  // R9
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_idle) |-> $past(rx_s, 2));

  // R13
  irq_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_rdy && f_rdy) |-> irq);
endmodule

bind uart_rx_core uart_rx_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .rx_en(rx_en),
  .frame_busy(frame_busy), .char_done(char_done), .f_rdy(f_rdy),
  .f_ore(f_ore), .f_idle(f_idle), .sr_seen(sr_seen), .data_rd(data_rd),
  .ie_rdy(ie_rdy), .irq(irq)
);

// File: tb/uart_rx_core_tb.sv
module uart_rx_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        rx_in = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done_flag = 0;

  uart_rx_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_in(rx_in),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      repeat (TDIV - 1) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic drain();
    logic [15:0] d;
    rd(2'd0, d); rd(2'd1, d); wr(2'd0, 16'h0000);
  endtask

  task automatic send(input logic [8:0] pl, input int nb, input logic stop_v,
                      input int os, input int glitch_bit);
    int bt;
    bt = os * TDIV;
    @(negedge clk);
    rx_in = 1'b0; wclk(bt);
    for (int i = 0; i < nb; i++) begin
      rx_in = pl[i];
      if (i == glitch_bit) begin
        wclk((os / 2) * TDIV);
        rx_in = ~pl[i]; wclk(TDIV);
        rx_in = pl[i];  wclk(bt - (os / 2) * TDIV - TDIV);
      end else begin
        wclk(bt);
      end
    end
    rx_in = stop_v; wclk(bt);
    rx_in = 1'b1;
    wclk(8);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd0, d); chk("R1 status after reset", d, 16'h0000);
    rd(2'd1, d); chk("R1 data after reset", d, 16'h0000);
    rd(2'd2, d); chk("R1 control after reset", d, 16'h0000);
    chk("R1 irq after reset", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_disabled();
    logic [15:0] d;
    send(9'h055, 8, 1'b1, 16, -1);
    rd(2'd0, d); chk("R12 no char while off", d, 16'h0000);
    wr(2'd2, 16'h2000);
    send(9'h055, 8, 1'b1, 16, -1);
    rd(2'd0, d); chk("R12 no char with receive off", d, 16'h0000);
  endtask

  task automatic t_basic();
    logic [15:0] d;
    wr(2'd2, 16'h2004);
    rd(2'd2, d); chk("R2 control readback", d, 16'h2004);
    send(9'h0A5, 8, 1'b1, 16, -1);
    rd(2'd0, d); chk("R2 status ready", d, 16'h0020);
    rd(2'd1, d); chk("R2 data 8N1", d, 16'h00A5);
    rd(2'd0, d); chk("R8 ready cleared", d, 16'h0000);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    wr(2'd2, 16'h2024);
    chk("R13 irq idle low", {15'b0, irq}, 16'h0000);
    send(9'h03C, 8, 1'b1, 16, -1);
    chk("R13 irq on ready", {15'b0, irq}, 16'h0001);
    drain();
    chk("R13 irq after drain", {15'b0, irq}, 16'h0000);
    wr(2'd2, 16'h2004);
  endtask

  task automatic t_nine();
    logic [15:0] d;
    wr(2'd2, 16'h3004);
    send(9'h1C3, 9, 1'b1, 16, -1);
    rd(2'd0, d); chk("R3 status", d, 16'h0020);
    rd(2'd1, d); chk("R3 9-bit data", d, 16'h01C3);
  endtask

  task automatic t_parity();
    logic [15:0] d;
    wr(2'd2, 16'h2404);
    send(9'h035, 8, 1'b1, 16, -1);
    rd(2'd0, d); chk("R4 even parity good", d, 16'h0020);
    rd(2'd1, d); chk("R4 7 data bits", d, 16'h0035);
    send(9'h0B5, 8, 1'b1, 16, -1);
    rd(2'd0, d); chk("R4 even parity bad", d, 16'h0021);
    rd(2'd1, d); chk("R4 parity bit hidden", d, 16'h0035);
    wr(2'd2, 16'h3604);
    send(9'h181, 9, 1'b1, 16, -1);
    rd(2'd0, d); chk("R4 odd parity good", d, 16'h0020);
    rd(2'd1, d); chk("R4 8 data bits", d, 16'h0081);
    wr(2'd2, 16'h3704);
    send(9'h081, 9, 1'b1, 16, -1);
    chk("R13 irq on parity error", {15'b0, irq}, 16'h0001);
    rd(2'd0, d); chk("R4 odd parity bad", d, 16'h0021);
    rd(2'd1, d);
    chk("R13 irq after clear", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_frame_break();
    logic [15:0] d;
    wr(2'd2, 16'h2004);
    send(9'h00F, 8, 1'b0, 16, -1);
    rd(2'd0, d); chk("R5 framing error", d, 16'h0022);
    rd(2'd1, d); chk("R5 data kept", d, 16'h000F);
    rd(2'd0, d); chk("R5 no spurious char", d, 16'h0000);
    send(9'h000, 8, 1'b0, 16, -1);
    rd(2'd0, d); chk("R10 break and framing", d, 16'h0122);
    rd(2'd1, d);
    rd(2'd0, d); chk("R10 break survives read pair", d, 16'h0100);
    wr(2'd0, 16'h0000);
    rd(2'd0, d); chk("R10 break cleared by write", d, 16'h0000);
  endtask

  task automatic t_noise();
    logic [15:0] d;
    send(9'h055, 8, 1'b1, 16, 2);
    rd(2'd0, d); chk("R6 noise flag", d, 16'h0024);
    rd(2'd1, d); chk("R6 majority data", d, 16'h0055);
  endtask

  task automatic t_overrun();
    logic [15:0] d;
    send(9'h011, 8, 1'b1, 16, -1);
    send(9'h022, 8, 1'b1, 16, -1);
    rd(2'd1, d); chk("R7 old char kept", d, 16'h0011);
    rd(2'd0, d); chk("R8 data read alone keeps overrun", d, 16'h0008);
    rd(2'd1, d);
    rd(2'd0, d); chk("R8 overrun cleared by pair", d, 16'h0000);
  endtask

  task automatic t_idle();
    logic [15:0] d;
    wr(2'd2, 16'h2014);
    send(9'h042, 8, 1'b1, 16, -1);
    wclk(2 * 16 * TDIV);
    rd(2'd0, d); chk("R9 idle not early", d, 16'h0020);
    chk("R13 idle irq not early", {15'b0, irq}, 16'h0000);
    wclk(9 * 16 * TDIV);
    rd(2'd0, d); chk("R9 idle after frame time", d, 16'h0030);
    chk("R13 idle irq", {15'b0, irq}, 16'h0001);
    rd(2'd1, d);
    rd(2'd0, d); chk("R8 idle cleared", d, 16'h0000);
    wr(2'd2, 16'h2004);
  endtask

  task automatic t_false_start();
    logic [15:0] d;
    @(negedge clk);
    rx_in = 1'b0; wclk(3 * TDIV); rx_in = 1'b1;
    wclk(2 * 16 * TDIV);
    rd(2'd0, d); chk("R11 short pulse ignored", d, 16'h0000);
    send(9'h05A, 8, 1'b1, 16, -1);
    rd(2'd0, d);
    rd(2'd1, d); chk("R11 next frame ok", d, 16'h005A);
  endtask

  task automatic t_os8();
    logic [15:0] d;
    wr(2'd2, 16'hA004);
    send(9'h096, 8, 1'b1, 8, -1);
    rd(2'd0, d); chk("R14 status 8x", d, 16'h0020);
    rd(2'd1, d); chk("R14 data 8x", d, 16'h0096);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    wclk(4);
    rst_n = 1'b1;
    wclk(4);
    t_reset();
    t_disabled();
    t_basic();
    t_irq();
    t_nine();
    drain();
    t_parity();
    drain();
    t_frame_break();
    drain();
    t_noise();
    drain();
    t_overrun();
    drain();
    t_idle();
    drain();
    t_false_start();
    drain();
    t_os8();
    finish_run();
  end
endmodule